// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five software localities currently owns a trusted-module register interface. Software in each locality reaches a one-byte ownership register through a byte-wide register bus. Address bits 14:12 pick the locality window, and the ownership register sits at offset 0x000 of each window. A locality asks for the interface by setting a request bit. The arbiter grants a free interface to the highest-numbered requester. It tells the current owner when others are waiting. Ownership moves only when the owner gives it up.

The arbiter drives the active-locality index and a valid flag, which the other register blocks use to gate their accesses. Every grant and every release raises a locality-change cause. Software reads this cause at offset 0x010 of any window and clears it by writing a one to it.

The owner state machine has two states. ST_FREE means no owner. ST_OWNED means one locality holds the interface. The GRANT transition (ST_FREE to ST_OWNED) fires on any clock edge at which at least one request is recorded. The RELEASE transition (ST_OWNED to ST_FREE) fires when the owner writes its give-up bit. No other transition exists.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality is active, `active_valid` is 0, `active_loc` is 0, `loc_change` is 0, and every ownership register reads 0x80.
- R2: Address bits 14:12 select the locality and the ownership register is at offset 0x000. A write to locality 5 to 7, or to any other offset except 0x010, has no effect. Reads there return 0x00.
- R3: A write with bit 1 set to a non-active locality's ownership register records a pending request. That register then reads bit 1 as 1 until the request is granted or withdrawn.
- R4: In ST_FREE with requests recorded, the highest-numbered requester is granted on the next clock edge (GRANT), and its pending bit clears.
- R5: While locality L owns the interface, `active_valid` is 1, `active_loc` is L, and L's ownership register reads bit 5 and bit 7 as 1. Bit 5 reads 0 in every other locality.
- R6: Bit 2 of the owner's ownership register reads 1 whenever any other locality has a recorded request. It reads 0 in non-owning localities.
- R7: A write with bit 5 set to the owner's ownership register returns the arbiter to ST_FREE on that clock edge (RELEASE).
- R8: A request written by the active locality is ignored and leaves no pending bit.
- R9: A write with bit 5 set to a non-active locality withdraws only that locality's own pending request. Bit 5 wins over bit 1 in the same byte. Ownership is unchanged.
- R10: Every GRANT and every RELEASE sets `loc_change`. It reads as bit 2 at offset 0x010. Writing a byte with bit 2 set there clears it, unless a GRANT or RELEASE happens on the same edge, in which case it stays set.
- R11: Ownership never moves between localities except through RELEASE followed by GRANT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register address; bits 14:12 select the locality |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for `addr` (combinational) |
| active_loc | output | 3 | Index of the owning locality, 0 when none |
| active_valid | output | 1 | An owner exists |
| loc_change | output | 1 | Locality-change interrupt cause |

## Verification
The bench drives the arbiter with five kinds of access pattern:
- A single request into an idle arbiter. This separates the cycle at which the request is recorded from the GRANT cycle.
- Several requests queued behind an owner, then released. This separates highest-number priority from arrival order.
- A request from the owner and a withdrawal from a waiting locality. These show whether ownership bits or pending bits are disturbed.
- Writes to locality 5 and to an unused offset. These show whether the address decode is honest.
- A cause clear placed on the same edge as a GRANT. This separates set-priority from clear-priority.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    typedef enum logic [0:0] {
        ST_FREE,
        ST_OWNED
    } own_state_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ACCESS,
        SEL_IRQ
    } rd_sel_t;

    localparam int BIT_VALID   = 7;
    localparam int BIT_ACTIVE  = 5;
    localparam int BIT_PENDING = 2;
    localparam int BIT_REQUEST = 1;
    localparam int BIT_CHANGE  = 2;

endpackage

// File: rtl/loc_reg_decode.sv
module loc_reg_decode
    import loc_arb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_LOC    = 5,
    parameter int LOC_W      = 3,
    parameter int WIN_LSB    = 12,
    parameter int OFF_ACCESS = 'h000,
    parameter int OFF_IRQ    = 'h010
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    output logic [NUM_LOC-1:0] req_vec,
    output logic [NUM_LOC-1:0] drop_vec,
    output logic               cause_clr,
    output rd_sel_t            sel,
    output logic [LOC_W-1:0]   sel_loc
);

    localparam logic [WIN_LSB-1:0] OFF_A   = WIN_LSB'(OFF_ACCESS);
    localparam logic [WIN_LSB-1:0] OFF_I   = WIN_LSB'(OFF_IRQ);
    localparam logic [LOC_W:0]     LOC_LIM = (LOC_W+1)'(NUM_LOC);

    logic [LOC_W-1:0]   loc;
    logic [WIN_LSB-1:0] offset;
    logic               loc_ok;
    logic               hit_access;
    logic               hit_irq;

    always_comb begin
        loc        = addr[WIN_LSB +: LOC_W];
        offset     = addr[WIN_LSB-1:0];
        loc_ok     = ({1'b0, loc} < LOC_LIM);
        hit_access = loc_ok && (offset == OFF_A);
        hit_irq    = loc_ok && (offset == OFF_I);
        sel_loc    = loc;
        if (hit_access)   sel = SEL_ACCESS;
        else if (hit_irq) sel = SEL_IRQ;
        else              sel = SEL_NONE;
        cause_clr  = wr_en && hit_irq && wdata[BIT_CHANGE];
    end

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_win
        logic win_wr;
        assign win_wr      = wr_en && hit_access && (loc == LOC_W'(g));
        assign req_vec[g]  = win_wr && wdata[BIT_REQUEST];
        assign drop_vec[g] = win_wr && wdata[BIT_ACTIVE];
    end

endmodule

// File: rtl/loc_req_tracker.sv
module loc_req_tracker #(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] req_vec,
    input  logic [NUM_LOC-1:0] drop_vec,
    input  logic [NUM_LOC-1:0] grant_vec,
    input  logic [NUM_LOC-1:0] own_vec,
    output logic [NUM_LOC-1:0] pend
);

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (drop_vec[g] || grant_vec[g])
                pend[g] <= 1'b0;
            else if (req_vec[g] && !own_vec[g])
                pend[g] <= 1'b1;
        end

        // R8: the owning locality never carries a recorded request
        a_r8_owner_not_pending: assert property (
            @(posedge clk) disable iff (!rst_n)
            own_vec[g] |-> !pend[g]
        );

        // R9: a withdrawal always leaves the bit clear on the next cycle
        a_r9_withdraw_clears: assert property (
            @(posedge clk) disable iff (!rst_n)
            drop_vec[g] |=> !pend[g]
        );
    end

endmodule

// File: rtl/loc_owner_fsm.sv
module loc_owner_fsm
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] pend,
    input  logic [NUM_LOC-1:0] drop_vec,
    input  logic               cause_clr,
    output logic [NUM_LOC-1:0] grant_vec,
    output logic [NUM_LOC-1:0] own_vec,
    output logic [LOC_W-1:0]   active_loc,
    output logic               active_valid,
    output logic               cause
);

    own_state_t       state, state_nx;
    logic [LOC_W-1:0] owner;
    logic [LOC_W-1:0] top_idx;
    logic             any_pend;
    logic             do_grant;
    logic             do_release;

    always_comb begin
        top_idx  = '0;
        any_pend = 1'b0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (pend[i]) begin
                top_idx  = LOC_W'(i);
                any_pend = 1'b1;
            end
        end
    end

    always_comb begin
        state_nx   = state;
        do_grant   = 1'b0;
        do_release = 1'b0;
        unique case (state)
            ST_FREE: begin
                if (any_pend) begin
                    do_grant = 1'b1;
                    state_nx = ST_OWNED;
                end
            end
            ST_OWNED: begin
                if (drop_vec[owner]) begin
                    do_release = 1'b1;
                    state_nx   = ST_FREE;
                end
            end
            default: state_nx = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FREE;
            owner <= '0;
            cause <= 1'b0;
        end else begin
            state <= state_nx;
            if (do_grant)        owner <= top_idx;
            if (do_grant || do_release) cause <= 1'b1;
            else if (cause_clr)  cause <= 1'b0;
        end
    end

    always_comb begin
        active_valid = (state == ST_OWNED);
        active_loc   = active_valid ? owner : '0;
        own_vec      = active_valid ? (NUM_LOC'(1) << owner) : '0;
        grant_vec    = do_grant ? (NUM_LOC'(1) << top_idx) : '0;
    end

    // R4: a free interface with recorded requests is owned on the next cycle
    a_r4_grant_next: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!active_valid && (pend != '0)) |=> active_valid
    );

    // R4: the granted locality outranks every request seen at the grant
    a_r4_highest: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(active_valid) |-> ((($past(pend) >> active_loc) >> 1) == '0)
    );

    // R7: an owner's give-up write ends ownership
    a_r7_release: assert property (
        @(posedge clk) disable iff (!rst_n)
        (active_valid && drop_vec[active_loc]) |=> !active_valid
    );

    // R11: without a give-up write the owner stays put
    a_r11_hold: assert property (
        @(posedge clk) disable iff (!rst_n)
        (active_valid && !drop_vec[active_loc]) |=> (active_valid && $stable(active_loc))
    );

    // R10: every ownership change leaves the cause set
    a_r10_cause_on_change: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($rose(active_valid) || $fell(active_valid)) |-> cause
    );

endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
    import loc_arb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_LOC = 5,
    parameter int WIN_LSB = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [2:0]  active_loc,
    output logic        active_valid,
    output logic        loc_change
);

    localparam int LOC_W = 3;

    logic [NUM_LOC-1:0] req_vec;
    logic [NUM_LOC-1:0] drop_vec;
    logic [NUM_LOC-1:0] grant_vec;
    logic [NUM_LOC-1:0] own_vec;
    logic [NUM_LOC-1:0] pend;
    logic               cause_clr;
    rd_sel_t            sel;
    logic [LOC_W-1:0]   sel_loc;
    logic [ADDR_W-1:0]  addr_int;

    assign addr_int = ADDR_W'(addr);

    loc_reg_decode #(
        .ADDR_W (ADDR_W),
        .NUM_LOC(NUM_LOC),
        .LOC_W  (LOC_W),
        .WIN_LSB(WIN_LSB)
    ) u_decode (
        .wr_en    (wr_en),
        .addr     (addr_int),
        .wdata    (wdata),
        .req_vec  (req_vec),
        .drop_vec (drop_vec),
        .cause_clr(cause_clr),
        .sel      (sel),
        .sel_loc  (sel_loc)
    );

    loc_req_tracker #(
        .NUM_LOC(NUM_LOC)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vec  (req_vec),
        .drop_vec (drop_vec),
        .grant_vec(grant_vec),
        .own_vec  (own_vec),
        .pend     (pend)
    );

    loc_owner_fsm #(
        .NUM_LOC(NUM_LOC),
        .LOC_W  (LOC_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend),
        .drop_vec    (drop_vec),
        .cause_clr   (cause_clr),
        .grant_vec   (grant_vec),
        .own_vec     (own_vec),
        .active_loc  (active_loc),
        .active_valid(active_valid),
        .cause       (loc_change)
    );

    logic [NUM_LOC-1:0] sel_mask;
    logic               sel_owns;
    logic               others_wait;

    always_comb begin
        sel_mask    = NUM_LOC'(1) << sel_loc;
        sel_owns    = |(own_vec & sel_mask);
        others_wait = sel_owns && (|(pend & ~sel_mask));
        rdata       = 8'h00;
        unique case (sel)
            SEL_ACCESS: begin
                rdata[BIT_VALID]   = 1'b1;
                rdata[BIT_ACTIVE]  = sel_owns;
                rdata[BIT_PENDING] = others_wait;
                rdata[BIT_REQUEST] = |(pend & sel_mask);
            end
            SEL_IRQ:  rdata[BIT_CHANGE] = loc_change;
            SEL_NONE: rdata = 8'h00;
            default:  rdata = 8'h00;
        endcase
    end

    // R5: the valid flag and the one-hot owner vector agree
    a_r5_owner_onehot: assert property (
        @(posedge clk) disable iff (!rst_n)
        active_valid |-> ($countones(own_vec) == 1)
    );

endmodule

// File: tb/tb_loc_arbiter.sv
module tb_loc_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  active_loc;
    logic        active_valid;
    logic        loc_change;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [12:0] exp;
        string       tag;
        logic [15:0] a;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #10 clk = ~clk;

    loc_arbiter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .active_loc(active_loc), .active_valid(active_valid),
        .loc_change(loc_change)
    );

    function automatic logic [12:0] ex(bit c, bit v, int l, logic [7:0] d);
        return {c, v, 3'(l), d};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic [15:0] a, input logic [12:0] e, input string tag);
        item_t it;
        addr = a;
        #1;
        it.exp = e; it.tag = tag; it.a = a;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    initial begin : monitor
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [12:0] got;
                it  = sb_q.pop_front();
                got = {loc_change, active_valid, active_loc, rdata};
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, got, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(16'h0000, ex(0,0,0,8'h80), "R1 loc0 access");
        chk(16'h4000, ex(0,0,0,8'h80), "R1 loc4 access");
        chk(16'h0010, ex(0,0,0,8'h00), "R1 cause clear");
        // R3 request recorded, R4 grant next edge
        wr(16'h2000, 8'h02);
        chk(16'h2000, ex(0,0,0,8'h82), "R3 pending loc2");
        tick();
        chk(16'h2000, ex(1,1,2,8'hA0), "R4 R5 grant loc2");
        // R10 clear cause
        wr(16'h0010, 8'h04);
        chk(16'h0010, ex(0,1,2,8'h00), "R10 cause cleared");
        // R8 request by owner ignored
        wr(16'h2000, 8'h02);
        chk(16'h2000, ex(0,1,2,8'hA0), "R8 owner request ignored");
        // R6 others pending
        wr(16'h1000, 8'h02);
        chk(16'h2000, ex(0,1,2,8'hA4), "R6 owner sees pending");
        chk(16'h1000, ex(0,1,2,8'h82), "R6 non-owner no bit2");
        // R9 withdrawal
        wr(16'h3000, 8'h02);
        wr(16'h4000, 8'h02);
        wr(16'h3000, 8'h20);
        chk(16'h3000, ex(0,1,2,8'h80), "R9 loc3 withdrawn");
        chk(16'h4000, ex(0,1,2,8'h82), "R9 loc4 still pending");
        chk(16'h1000, ex(0,1,2,8'h82), "R11 owner unchanged");
        // R2 decode
        wr(16'h5000, 8'h02);
        chk(16'h5000, ex(0,1,2,8'h00), "R2 loc5 window empty");
        wr(16'h0004, 8'h02);
        chk(16'h0000, ex(0,1,2,8'h80), "R2 other offset no effect");
        // R7 release then R4 highest grant
        wr(16'h2000, 8'h20);
        chk(16'h2000, ex(1,0,0,8'h80), "R7 release");
        tick();
        chk(16'h4000, ex(1,1,4,8'hA4), "R4 highest loc4");
        wr(16'h4000, 8'h20);
        tick();
        chk(16'h1000, ex(1,1,1,8'hA0), "R4 remaining loc1");
        // R10 set wins over clear
        wr(16'h0010, 8'h04);
        wr(16'h1000, 8'h20);
        chk(16'h0010, ex(1,0,0,8'h04), "R10 release sets cause");
        wr(16'h0010, 8'h04);
        chk(16'h0010, ex(0,0,0,8'h00), "R10 clear when free");
        wr(16'h3000, 8'h02);
        wr(16'h0010, 8'h04);
        chk(16'h3000, ex(1,1,3,8'hA0), "R10 grant beats clear");
        #5;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule